// File: doc/BRIEF.md
# Adaptive On-Time Buck Switching Controller

This block is the digital core of a constant-on-time synchronous buck controller. Comparator flags come in from the analog side: feedback below the reference, feedback above the +10% level, inductor current at zero, and valley current limit. The block turns them into high-side and low-side gate enables. Each time feedback drops below the reference, it issues one high-side pulse of a programmed number of clock cycles. The low side then turns on for at least a minimum off-time. A fixed dead time separates any turn-off from the opposite turn-on.

A 2-bit mode input selects the light-load behaviour:

- Forced-continuous mode keeps one switch on at all times.
- Power-save mode releases the low side at the current zero crossing. It does this only after a run of switching cycles that all reached zero.
- Ultrasonic mode also releases at zero crossings. It adds a timer that forces a discharge of the output when no high-side pulse follows in time.

An overshoot of the feedback in a light-load mode triggers a forced discharge through the low side. A disable input parks both switches off.

Top module: `cot_ctrl`

## Requirements
- R1: While rst_ni is low both outputs are low. Disable_i high forces both outputs low from the next clock, and no high-side pulse starts while it stays high.
- R2: With fb_low_i high, ilim_i low and the controller idle or past its minimum off-time, hs_o rises after the dead time and stays high for exactly ton_cnt_i clock cycles when ton_cnt_i >= MIN_ON_CYC.
- R3: A ton_cnt_i below MIN_ON_CYC, including zero, yields a high-side pulse of exactly MIN_ON_CYC cycles.
- R4: hs_o and ls_o are never high together. Exactly DEAD_CYC cycles with both low separate hs_o falling from ls_o rising, and ls_o falling from hs_o rising.
- R5: ls_o stays high for at least MIN_OFF_CYC cycles after it rises. fb_low_i within that window is ignored. A level still held when the window ends starts the next pulse, which makes the low-side phase exactly MIN_OFF_CYC cycles.
- R6: Mode 2'b00 (forced-continuous): ls_o stays high until fb_low_i, whatever zero_cross_i does.
- R7: Mode 2'b01 (power-save): a low-side phase counts as a zero cycle if zero_cross_i was high during it. The first 8 such low-side phases after entering the mode end only on fb_low_i. Once 8 in a row have been counted, each low-side phase ends at the zero crossing once the minimum off-time has elapsed, leaving both outputs low.
- R8: In power-save, a low-side phase without any zero crossing clears the count, so the following phases again hold the low side until fb_low_i.
- R9: Mode 2'b10 (ultrasonic): the low side ends at the zero crossing after every pulse. A timer of psv_tmo_i cycles restarts at the end of each high-side pulse. If it expires with no new pulse, ls_o turns on and is held, through zero crossings, until fb_low_i starts a pulse.
- R10: In an active light-load mode, fb_high_i turns the low side on and holds it until fb_low_i starts a pulse. Power-save must then collect 8 new zero cycles before releasing the low side again.
- R11: While ilim_i is high and ls_o is high, ls_o stays high and no high-side pulse starts. Once ilim_i drops with fb_low_i still high, a pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| disable_i | input | 1 | Forces both gate enables low |
| fb_low_i | input | 1 | Feedback below reference |
| fb_high_i | input | 1 | Feedback above the +10% level |
| zero_cross_i | input | 1 | Inductor current at or below zero |
| ilim_i | input | 1 | Valley current limit tripped |
| ton_cnt_i | input | TON_W | High-side on-time in clock cycles |
| psv_tmo_i | input | TMO_W | Ultrasonic timeout in clock cycles |
| mode_i | input | 2 | 00 forced-continuous, 01 power-save, 10 ultrasonic, 11 treated as 00 |
| hs_o | output | 1 | High-side gate enable |
| ls_o | output | 1 | Low-side gate enable |

## Verification
The assertions assume the comparator flags are synchronous to clk_i and change only between edges. They also assume ton_cnt_i and mode_i are steady across a pulse, so a clamp or hold failure points at the sequencer and not at a moving input. The stimulus changes inputs only a short time after a rising edge. It pulses fb_low_i for one cycle, except where a held level is the point of the check, and changes the mode only after a disable has parked the controller. The minimum-width checks are relaxed when disable cuts a phase short, because that cut is the one legal way to end a phase early.

// File: rtl/cot_pkg.sv
package cot_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DT_HS = 3'd1,
    PH_ON    = 3'd2,
    PH_DT_LS = 3'd3,
    PH_LS    = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    MODE_FCM   = 2'b00,
    MODE_PSAVE = 2'b01,
    MODE_ULTRA = 2'b10
  } mode_e;

endpackage

// File: rtl/cot_timer.sv
module cot_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/cot_zc_filter.sv
module cot_zc_filter #(
  parameter int RUN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic hit_i,
  input  logic upd_i,
  output logic full_o
);

  localparam int CW = $clog2(RUN + 1);
  localparam logic [CW-1:0] RUN_V = CW'(RUN);

  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          seen;

  assign seen = seen_q | hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= 1'b0;
    else if (clr_i || arm_i)  seen_q <= 1'b0;
    else if (hit_i)           seen_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (upd_i)   cnt_q <= !seen ? '0 : (cnt_q == RUN_V) ? cnt_q : cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == RUN_V);

  AST_ZC_MISS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !clr_i && !seen_q && !hit_i |=> !full_o); // R8

  AST_ZC_ENTRY_ON_UPDATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(upd_i)); // R7

endmodule

// File: rtl/cot_ctrl.sv
module cot_ctrl
  import cot_pkg::*;
#(
  parameter int TON_W       = 10,
  parameter int TMO_W       = 12,
  parameter int MIN_ON_CYC  = 10,
  parameter int MIN_OFF_CYC = 32,
  parameter int DEAD_CYC    = 2,
  parameter int ZC_RUN      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             disable_i,
  input  logic             fb_low_i,
  input  logic             fb_high_i,
  input  logic             zero_cross_i,
  input  logic             ilim_i,
  input  logic [TON_W-1:0] ton_cnt_i,
  input  logic [TMO_W-1:0] psv_tmo_i,
  input  logic [1:0]       mode_i,
  output logic             hs_o,
  output logic             ls_o
);

  localparam int OFF_W = $clog2(MIN_OFF_CYC + 1);
  localparam int DT_W  = $clog2(DEAD_CYC + 1);
  localparam int PH_W0 = (TON_W > OFF_W) ? TON_W : OFF_W;
  localparam int PH_W  = (PH_W0 > DT_W) ? PH_W0 : DT_W;
  localparam int LEN_W = PH_W + 1;
  localparam logic [TON_W-1:0] MIN_ON_V = TON_W'(MIN_ON_CYC);
  localparam logic [PH_W-1:0]  DT_LD    = PH_W'(DEAD_CYC - 1);
  localparam logic [PH_W-1:0]  OFF_LD   = PH_W'(MIN_OFF_CYC - 1);

  phase_e            ph_q, ph_d;
  logic              ph_load, ph_done;
  logic [PH_W-1:0]   ph_val;
  logic [TON_W-1:0]  ton_eff;
  logic              force_q, force_d;
  logic              us_arm_q, us_arm_d, us_load, us_done;
  logic              zc_full, zc_clr, zc_arm, zc_upd;
  logic              start_ok, ll_on, us_exp, smart_hit, pull_low;

  assign ton_eff   = (ton_cnt_i < MIN_ON_V) ? MIN_ON_V : ton_cnt_i;
  assign start_ok  = fb_low_i & ~ilim_i;
  assign ll_on     = (mode_i == MODE_ULTRA) | ((mode_i == MODE_PSAVE) & zc_full);
  assign us_exp    = (mode_i == MODE_ULTRA) & us_arm_q & us_done;
  assign smart_hit = ll_on & fb_high_i;
  assign pull_low  = smart_hit | us_exp;
  assign zc_clr    = disable_i | smart_hit | (mode_i != MODE_PSAVE);

  cot_timer #(.W(PH_W)) u_ph_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ph_load),
    .val_i  (ph_val),
    .done_o (ph_done)
  );

  cot_timer #(.W(TMO_W)) u_us_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (us_load),
    .val_i  (psv_tmo_i),
    .done_o (us_done)
  );

  cot_zc_filter #(.RUN(ZC_RUN)) u_zc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (zc_clr),
    .arm_i  (zc_arm),
    .hit_i  (ls_o & zero_cross_i),
    .upd_i  (zc_upd),
    .full_o (zc_full)
  );

  always_comb begin
    ph_d     = ph_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    us_load  = 1'b0;
    zc_arm   = 1'b0;
    zc_upd   = 1'b0;
    force_d  = force_q;
    us_arm_d = us_arm_q;
    // overshoot or ultrasonic expiry latches a forced discharge
    if (pull_low && ph_q != PH_DT_HS && ph_q != PH_ON) force_d = 1'b1;
    case (ph_q)
      PH_IDLE: begin
        if (start_ok) begin
          ph_d = PH_DT_HS; ph_load = 1'b1; ph_val = DT_LD;
        end else if (force_q || pull_low) begin
          ph_d = PH_DT_LS; ph_load = 1'b1; ph_val = DT_LD;
        end
      end
      PH_DT_HS: begin
        if (ph_done) begin
          ph_d = PH_ON; ph_load = 1'b1; ph_val = PH_W'(ton_eff) - PH_W'(1);
        end
      end
      PH_ON: begin
        if (ph_done) begin
          ph_d = PH_DT_LS; ph_load = 1'b1; ph_val = DT_LD;
          us_load = 1'b1; us_arm_d = 1'b1;
        end
      end
      PH_DT_LS: begin
        if (ph_done) begin
          ph_d = PH_LS; ph_load = 1'b1; ph_val = OFF_LD; zc_arm = 1'b1;
        end
      end
      PH_LS: begin
        if (ph_done && !ilim_i) begin
          if (fb_low_i) begin
            ph_d = PH_DT_HS; ph_load = 1'b1; ph_val = DT_LD; zc_upd = 1'b1;
          end else if (ll_on && !force_q && !pull_low && zero_cross_i) begin
            ph_d = PH_IDLE; zc_upd = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
    if (ph_d == PH_DT_HS && ph_q != PH_DT_HS) begin
      force_d  = 1'b0;
      us_arm_d = 1'b0;
    end
    if (disable_i) begin
      ph_d     = PH_IDLE;
      ph_load  = 1'b0;
      us_load  = 1'b0;
      zc_arm   = 1'b0;
      zc_upd   = 1'b0;
      force_d  = 1'b0;
      us_arm_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      force_q  <= 1'b0;
      us_arm_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      force_q  <= force_d;
      us_arm_q <= us_arm_d;
    end
  end

  assign hs_o = (ph_q == PH_ON);
  assign ls_o = (ph_q == PH_LS);

  // phase length trackers for the width checks
  logic [LEN_W-1:0] hs_len_q, ls_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_len_q <= '0;
      ls_len_q <= '0;
    end else begin
      hs_len_q <= !hs_o ? '0 : (&hs_len_q) ? hs_len_q : hs_len_q + 1'b1;
      ls_len_q <= !ls_o ? '0 : (&ls_len_q) ? ls_len_q : ls_len_q + 1'b1;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o)); // R4

  AST_HS_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> $past(!ls_o)); // R4

  AST_DISABLE_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !hs_o && !ls_o); // R1

  AST_MIN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_o) && !$past(disable_i) |-> hs_len_q >= LEN_W'(MIN_ON_CYC)); // R3

  AST_MIN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_o) && !$past(disable_i) |-> ls_len_q >= LEN_W'(MIN_OFF_CYC)); // R5

  AST_ILIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i && ls_o && !disable_i |=> ls_o); // R11

  AST_FCM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FCM) && ls_o && !fb_low_i && !disable_i |=> ls_o); // R6

endmodule

// File: tb/tb_cot_ctrl.sv
module tb_cot_ctrl;

  localparam int TON_W   = 10;
  localparam int TMO_W   = 12;
  localparam int MIN_ON  = 10;
  localparam int MIN_OFF = 32;
  localparam int DEAD    = 2;
  localparam int NVEC    = 6;
  // {ton_cnt, expected high-side width}
  localparam logic [15:0] VEC [NVEC] = '{16'h1414, 16'h050A, 16'h0A0A, 16'h000A, 16'h2525, 16'h0B0B};

  logic clk_i = 1'b0;
  logic rst_ni, disable_i, fb_low_i, fb_high_i, zero_cross_i, ilim_i;
  logic [TON_W-1:0] ton_cnt_i;
  logic [TMO_W-1:0] psv_tmo_i;
  logic [1:0] mode_i;
  logic hs_o, ls_o;

  always #4 clk_i = ~clk_i;

  cot_ctrl #(.TON_W(TON_W), .TMO_W(TMO_W), .MIN_ON_CYC(MIN_ON), .MIN_OFF_CYC(MIN_OFF),
             .DEAD_CYC(DEAD), .ZC_RUN(8)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .disable_i(disable_i), .fb_low_i(fb_low_i),
    .fb_high_i(fb_high_i), .zero_cross_i(zero_cross_i), .ilim_i(ilim_i),
    .ton_cnt_i(ton_cnt_i), .psv_tmo_i(psv_tmo_i), .mode_i(mode_i),
    .hs_o(hs_o), .ls_o(ls_o));

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  // output monitor, sampled mid-cycle
  logic prev_hs = 1'b0, prev_ls = 1'b0;
  int cnt_hs = 0, cnt_ls = 0, last_hs_w = 0, last_ls_w = 0;
  int gap = 0, gap_h = 0, gap_l = 0, hs_rises = 0, ls_rises = 0;
  int since_hs_fall = 0, rise_after_hs = 0;
  bit overlap = 1'b0;

  always @(negedge clk_i) begin
    if (hs_o && ls_o) overlap = 1'b1;
    if (hs_o) cnt_hs = cnt_hs + 1;
    else if (prev_hs) begin last_hs_w = cnt_hs; cnt_hs = 0; end
    if (ls_o) cnt_ls = cnt_ls + 1;
    else if (prev_ls) begin last_ls_w = cnt_ls; cnt_ls = 0; end
    if (!hs_o && prev_hs) since_hs_fall = 1;
    else if (!hs_o) since_hs_fall = since_hs_fall + 1;
    if (!hs_o && !ls_o) gap = gap + 1;
    else begin
      if (hs_o && !prev_hs) begin gap_h = gap; hs_rises = hs_rises + 1; end
      if (ls_o && !prev_ls) begin gap_l = gap; ls_rises = ls_rises + 1; rise_after_hs = since_hs_fall; end
      gap = 0;
    end
    prev_hs = hs_o;
    prev_ls = ls_o;
  end

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire();
    fb_low_i = 1'b1;
    step();
    fb_low_i = 1'b0;
  endtask

  task automatic wait_hs_rise(output bit ok);
    int r = hs_rises;
    ok = 1'b0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      step();
      if (hs_rises != r) ok = 1'b1;
    end
  endtask

  task automatic wait_ls_rise(output bit ok);
    int r = ls_rises;
    ok = 1'b0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      step();
      if (ls_rises != r) ok = 1'b1;
    end
  endtask

  task automatic park();
    disable_i = 1'b1;
    step();
    disable_i = 1'b0;
    step();
  endtask

  task automatic report();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  localparam int W_CYC = 20 + 2 * DEAD + MIN_OFF + 20;

  initial begin
    bit ok;
    int r0;
    rst_ni = 1'b0; disable_i = 1'b0; fb_low_i = 1'b0; fb_high_i = 1'b0;
    zero_cross_i = 1'b0; ilim_i = 1'b0; ton_cnt_i = 20; psv_tmo_i = 200; mode_i = 2'b00;
    waitn(3);
    check(!hs_o && !ls_o, "R1 reset", {hs_o, ls_o}, 0);
    rst_ni = 1'b1;
    step();
    check(!hs_o && !ls_o, "R1 after reset", {hs_o, ls_o}, 0);

    // forced-continuous vector table
    for (int v = 0; v < NVEC; v++) begin
      ton_cnt_i = TON_W'(VEC[v][15:8]);
      fire();
      waitn(W_CYC);
      check(last_hs_w == int'(VEC[v][7:0]), (VEC[v][15:8] < MIN_ON) ? "R3 clamp" : "R2 width",
            last_hs_w, int'(VEC[v][7:0]));
      check(gap_l == DEAD, "R4 gap before ls", gap_l, DEAD);
      check(ls_o, "R6 ls held in FCM", ls_o, 1);
      if (v > 0) check(gap_h == DEAD, "R4 gap before hs", gap_h, DEAD);
    end
    ton_cnt_i = 20;

    // R6: zero crossing has no effect in forced-continuous
    zero_cross_i = 1'b1;
    waitn(3 * MIN_OFF);
    check(ls_o, "R6 zc ignored", ls_o, 1);
    zero_cross_i = 1'b0;

    // R5: early trigger ignored, held trigger fires at window end
    fire();
    wait_ls_rise(ok);
    check(ok, "R5 ls rise", ok, 1);
    r0 = hs_rises;
    fire();
    waitn(3 * MIN_OFF);
    check(hs_rises == r0 && ls_o, "R5 early fb_low ignored", hs_rises - r0, 0);
    fire();
    wait_ls_rise(ok);
    fb_low_i = 1'b1;
    wait_hs_rise(ok);
    fb_low_i = 1'b0;
    check(last_ls_w == MIN_OFF, "R5 min off width", last_ls_w, MIN_OFF);
    waitn(W_CYC);

    // R11: valley limit holds low side and blocks pulses
    r0 = hs_rises;
    ilim_i = 1'b1;
    fb_low_i = 1'b1;
    waitn(3 * MIN_OFF);
    check(hs_rises == r0 && ls_o, "R11 ilim hold", hs_rises - r0, 0);
    ilim_i = 1'b0;
    wait_hs_rise(ok);
    fb_low_i = 1'b0;
    check(ok, "R11 pulse after release", ok, 1);
    waitn(W_CYC);

    // R1: disable mid-pulse and while triggered
    fire();
    wait_hs_rise(ok);
    disable_i = 1'b1;
    step();
    check(!hs_o && !ls_o, "R1 disable parks", {hs_o, ls_o}, 0);
    r0 = hs_rises;
    fire();
    waitn(50);
    check(hs_rises == r0 && !ls_o, "R1 no pulse while disabled", hs_rises - r0, 0);
    disable_i = 1'b0;
    step();

    // R7: power-save entry after 8 zero cycles
    mode_i = 2'b01;
    zero_cross_i = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      fire();
      waitn(W_CYC);
      check(ls_o, "R7 held before entry", ls_o, 1);
    end
    fire();
    waitn(W_CYC);
    check(!ls_o && !hs_o, "R7 released at zc", ls_o, 0);
    check(last_ls_w == MIN_OFF, "R7 release after min off", last_ls_w, MIN_OFF);

    // R10: overshoot forces discharge and exits power-save
    r0 = hs_rises;
    fb_high_i = 1'b1;
    step();
    fb_high_i = 1'b0;
    waitn(3 * MIN_OFF);
    check(ls_o && hs_rises == r0, "R10 forced discharge", ls_o, 1);
    fire();
    waitn(W_CYC);
    check(hs_rises == r0 + 1, "R10 normal pulse follows", hs_rises - r0, 1);
    check(ls_o, "R10 power-save left", ls_o, 1);

    // R8: a cycle without zero crossing clears the count
    park();
    for (int k = 1; k <= 9; k++) begin
      fire();
      waitn(W_CYC);
    end
    check(!ls_o, "R8 entry reached", ls_o, 0);
    zero_cross_i = 1'b0;
    fire();
    waitn(W_CYC);
    check(ls_o, "R8 no zc holds ls", ls_o, 1);
    fire();
    waitn(W_CYC);
    zero_cross_i = 1'b1;
    fire();
    waitn(W_CYC);
    check(ls_o, "R8 count cleared", ls_o, 1);

    // R9: ultrasonic timeout
    park();
    mode_i = 2'b10;
    zero_cross_i = 1'b1;
    fire();
    waitn(W_CYC);
    check(!ls_o, "R9 zc release", ls_o, 0);
    check(last_ls_w == MIN_OFF, "R9 release width", last_ls_w, MIN_OFF);
    wait_ls_rise(ok);
    check(ok && rise_after_hs >= 200 && rise_after_hs <= 200 + DEAD + 3,
          "R9 timeout rise", rise_after_hs, 200 + DEAD + 2);
    waitn(3 * MIN_OFF);
    check(ls_o, "R9 forced ls held through zc", ls_o, 1);
    fire();
    wait_hs_rise(ok);
    check(ok, "R9 pulse ends discharge", ok, 1);
    waitn(W_CYC);

    check(!overlap, "R4 no overlap", overlap, 0);

    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule